// File: doc/BRIEF.md
# Multiplexed External Data Bus Controller

This block runs read and write cycles to an external data memory for a small 8-bit core. A single byte-wide port carries the low address byte first and then the data. A second port carries the high address byte. An address latch enable (ALE) output tells an external latch when to capture the low address. Two active-low strobes mark the read and the write.

The core raises a one-cycle request that carries a direction flag, an address, write data and a 2-bit wait-state count. The block takes the request only while it is idle. It then runs an access of four phases: ALE high, address hold, strobe, and tail. The strobe phase lasts one cycle plus the wait-state count. The block ends the access with a one-cycle done pulse, and for a read it returns the byte it sampled.

Between accesses ALE does not toggle. It rests at a level chosen by an idle-polarity input. The two ports show the core's own port register values. The low port is driven or floated according to an idle-drive input.

Top module: `xbus_ctrl`

## Requirements
- R1: While idle, `ale_o` rests high when `ale_low_idle_i`=0 and low when it is 1. `rd_n_o` and `wr_n_o` are both 1. `lo_out_o` equals `p0_reg_i`, `lo_oe_o` equals `p0_drive_idle_i`, and `hi_out_o` equals `p2_reg_i`. This is also the state right after reset.
- R2: A request is taken in an idle cycle when `req_i`=1. The address phase then runs over the next two cycles: ALE is 1 in the first cycle and 0 in the second. In both cycles `lo_oe_o`=1, `lo_out_o` carries the low address byte, and both strobes are 1.
- R3: When `wr_i`=1 (write), the strobe phase holds `wr_n_o`=0 and `rd_n_o`=1. During it, `lo_oe_o`=1 and `lo_out_o` carries the write data.
- R4: When `wr_i`=0 (read), the strobe phase holds `rd_n_o`=0 and `wr_n_o`=1, with `lo_oe_o`=0. `rdata_o` takes the value of `lo_in_i` present in the last strobe cycle.
- R5: The strobe phase lasts 1+ws cycles, where ws is the 2-bit `ws_i` value (0 to 3). A whole access therefore spans 4+ws cycles.
- R6: `done_o` is 1 for exactly one cycle, the last cycle of the access. In that cycle ALE is 0 and both strobes are 1. A write keeps its data driven there, and a read keeps the port floating. For a read, `rdata_o` already holds the sampled byte in that cycle.
- R7: The high port carries `addr_i[15:8]` when `wide_i`=1. It carries `p2_reg_i` when `wide_i`=0 (8-bit indirect access). With `wide_i`=1 the high port stays constant for the whole access.
- R8: The direction, wait-state count, address, width flag and write data are captured when the request is taken. Changes on those inputs during an access have no effect, and requests made during an access are ignored.
- R9: At most one strobe is low at any time. The low port is floating whenever the read strobe is low, even when the idle drive is enabled.
- R10: In the cycle after `done_o`, the block is idle again, with the R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| wide_i | input | 1 | 1 = 16-bit address, 0 = 8-bit indirect |
| addr_i | input | 16 | Access address |
| wdata_i | input | 8 | Write data |
| ws_i | input | 2 | Wait-state count |
| ale_low_idle_i | input | 1 | ALE rests low when 1, high when 0 |
| p0_reg_i | input | 8 | Low port register value |
| p0_drive_idle_i | input | 1 | Low port driven (1) or floated (0) while idle |
| p2_reg_i | input | 8 | High port register value |
| lo_in_i | input | 8 | Low port input from the pads |
| lo_out_o | output | 8 | Low port output value |
| lo_oe_o | output | 1 | Low port output enable |
| hi_out_o | output | 8 | High port output value |
| ale_o | output | 1 | Address latch enable |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| rdata_o | output | 8 | Read data |
| done_o | output | 1 | One-cycle access completion |

## Verification
The hardest case to reach from the ports is a request that arrives while an access is already running, carrying different direction, wait states, address and data. The bench must show that this request changes nothing in the access in flight and never starts a cycle of its own. To get there, each access raises `req_i` again during its address phase with scrambled inputs, and scrambles the captured inputs for the rest of the access. The bench then checks every cycle of the running access and the idle cycle after done. Read data changes on `lo_in_i` in every strobe cycle, so only a sample taken in the last strobe cycle matches the expected byte.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_HOLD = 3'd2,
    PH_STRB = 3'd3,
    PH_TAIL = 3'd4
  } xbus_phase_t;

  // Cycles the read or write strobe stays low for a wait-state count.
  function automatic int strobe_cycles(input int ws);
    return ws + 1;
  endfunction

  // Cycles of one whole access, from the ALE cycle to the done cycle.
  function automatic int access_cycles(input int ws);
    return strobe_cycles(ws) + 3;
  endfunction

endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int WSW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [WSW-1:0]    ws_i,
  output xbus_phase_t       phase_o,
  output logic              wr_q_o,
  output logic [WSW-1:0]    ws_q_o,
  output logic              accept_o,
  output logic              strobe_last_o,
  output logic              done_o
);

  xbus_phase_t    phase;
  logic [WSW-1:0] cnt;
  logic           wr_q;
  logic [WSW-1:0] ws_q;

  assign accept_o      = (phase == PH_IDLE) && req_i;
  assign strobe_last_o = (phase == PH_STRB) && (cnt == ws_q);
  assign done_o        = (phase == PH_TAIL);
  assign phase_o       = phase;
  assign wr_q_o        = wr_q;
  assign ws_q_o        = ws_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      wr_q  <= 1'b0;
      ws_q  <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (accept_o) begin
          phase <= PH_ADDR;
          wr_q  <= wr_i;
          ws_q  <= ws_i;
        end
        PH_ADDR: phase <= PH_HOLD;
        PH_HOLD: begin
          phase <= PH_STRB;
          cnt   <= '0;
        end
        PH_STRB: begin
          if (strobe_last_o) phase <= PH_TAIL;
          else               cnt   <= cnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R6: completion is a single-cycle pulse
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10: the cycle after completion is idle
  assert_idle_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (phase == PH_IDLE));

  // R8: no acceptance while an access runs
  assert_no_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> !accept_o);

endmodule

// File: rtl/xbus_latch.sv
module xbus_latch #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  logic          sample_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wide_i,
  input  logic [DW-1:0] lo_in_i,
  output logic [AW-1:0] addr_q_o,
  output logic [DW-1:0] wdata_q_o,
  output logic          wide_q_o,
  output logic [DW-1:0] rdata_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q_o  <= '0;
      wdata_q_o <= '0;
      wide_q_o  <= 1'b0;
    end else if (accept_i) begin
      addr_q_o  <= addr_i;
      wdata_q_o <= wdata_i;
      wide_q_o  <= wide_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_o <= '0;
    else if (sample_i) rdata_o <= lo_in_i;
  end

  // R8: captured request fields only move on acceptance
  assert_addr_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i |=> $stable(addr_q_o) && $stable(wdata_q_o) && $stable(wide_q_o));

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int DW  = 8,
  parameter int AW  = 16,
  parameter int WSW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  xbus_phase_t    phase_i,
  input  logic           wr_q_i,
  input  logic [WSW-1:0] ws_q_i,
  input  logic [AW-1:0]  addr_q_i,
  input  logic [DW-1:0]  wdata_q_i,
  input  logic           wide_q_i,
  input  logic           ale_low_idle_i,
  input  logic [DW-1:0]  p0_reg_i,
  input  logic           p0_drive_idle_i,
  input  logic [AW-DW-1:0] p2_reg_i,
  output logic [DW-1:0]  lo_out_o,
  output logic           lo_oe_o,
  output logic [AW-DW-1:0] hi_out_o,
  output logic           ale_o,
  output logic           rd_n_o,
  output logic           wr_n_o
);

  localparam int HW    = AW - DW;
  localparam int RUN_W = WSW + 2;

  logic in_access;
  logic addr_phase;
  logic data_phase;

  assign in_access  = (phase_i != PH_IDLE);
  assign addr_phase = (phase_i == PH_ADDR) || (phase_i == PH_HOLD);
  assign data_phase = (phase_i == PH_STRB) || (phase_i == PH_TAIL);

  always_comb begin
    lo_out_o = p0_reg_i;
    lo_oe_o  = p0_drive_idle_i;
    if (addr_phase) begin
      lo_out_o = addr_q_i[DW-1:0];
      lo_oe_o  = 1'b1;
    end else if (data_phase) begin
      lo_out_o = wdata_q_i;
      lo_oe_o  = wr_q_i;
    end
  end

  always_comb begin
    if (in_access && wide_q_i) hi_out_o = addr_q_i[AW-1:DW];
    else                       hi_out_o = p2_reg_i;
  end

  assign ale_o  = (phase_i == PH_IDLE) ? !ale_low_idle_i : (phase_i == PH_ADDR);
  assign rd_n_o = !((phase_i == PH_STRB) && !wr_q_i);
  assign wr_n_o = !((phase_i == PH_STRB) &&  wr_q_i);

  // Length of the current low run of either strobe, for the checker below.
  logic [RUN_W-1:0] low_run;
  logic             strobe_n;
  assign strobe_n = rd_n_o && wr_n_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_run <= '0;
    else if (strobe_n) low_run <= '0;
    else               low_run <= low_run + 1'b1;
  end

  // R9: never both strobes low
  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n_o || wr_n_o);

  // R9: low port floats while the read strobe is low
  assert_float_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> !lo_oe_o);

  // R2: strobes stay high while ALE is high
  assert_strobes_high_ale_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_o && in_access) |-> (rd_n_o && wr_n_o));

  // R5: strobe low run lasts 1+ws cycles
  assert_strobe_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_n) |-> (int'(low_run) == strobe_cycles(int'(ws_q_i))));

  // R7: wide address held on the high port through the access
  assert_hi_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_access && wide_q_i && $past(phase_i != PH_IDLE)) |-> $stable(hi_out_o));

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int DW  = 8,
  parameter int AW  = 16,
  parameter int WSW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic              wide_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [WSW-1:0]    ws_i,
  input  logic              ale_low_idle_i,
  input  logic [DW-1:0]     p0_reg_i,
  input  logic              p0_drive_idle_i,
  input  logic [AW-DW-1:0]  p2_reg_i,
  input  logic [DW-1:0]     lo_in_i,
  output logic [DW-1:0]     lo_out_o,
  output logic              lo_oe_o,
  output logic [AW-DW-1:0]  hi_out_o,
  output logic              ale_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic [DW-1:0]     rdata_o,
  output logic              done_o
);

  xbus_phase_t    phase;
  logic           wr_q;
  logic [WSW-1:0] ws_q;
  logic           accept;
  logic           strobe_last;
  logic           sample_rd;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic           wide_q;

  assign sample_rd = strobe_last && !wr_q;

  xbus_seq #(.WSW(WSW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .wr_i          (wr_i),
    .ws_i          (ws_i),
    .phase_o       (phase),
    .wr_q_o        (wr_q),
    .ws_q_o        (ws_q),
    .accept_o      (accept),
    .strobe_last_o (strobe_last),
    .done_o        (done_o)
  );

  xbus_latch #(.DW(DW), .AW(AW)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (accept),
    .sample_i  (sample_rd),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .wide_i    (wide_i),
    .lo_in_i   (lo_in_i),
    .addr_q_o  (addr_q),
    .wdata_q_o (wdata_q),
    .wide_q_o  (wide_q),
    .rdata_o   (rdata_o)
  );

  xbus_pins #(.DW(DW), .AW(AW), .WSW(WSW)) u_pins (
    .clk             (clk),
    .rst_n           (rst_n),
    .phase_i         (phase),
    .wr_q_i          (wr_q),
    .ws_q_i          (ws_q),
    .addr_q_i        (addr_q),
    .wdata_q_i       (wdata_q),
    .wide_q_i        (wide_q),
    .ale_low_idle_i  (ale_low_idle_i),
    .p0_reg_i        (p0_reg_i),
    .p0_drive_idle_i (p0_drive_idle_i),
    .p2_reg_i        (p2_reg_i),
    .lo_out_o        (lo_out_o),
    .lo_oe_o         (lo_oe_o),
    .hi_out_o        (hi_out_o),
    .ale_o           (ale_o),
    .rd_n_o          (rd_n_o),
    .wr_n_o          (wr_n_o)
  );

  // R4: read data only changes at the end of a read strobe
  assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n_o |=> $stable(rdata_o));

endmodule

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_i = 1'b0, wr_i = 1'b0, wide_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [1:0] ws_i = '0;
  logic       ale_low_idle_i = 1'b0;
  logic [7:0] p0_reg_i = 8'hFF;
  logic       p0_drive_idle_i = 1'b1;
  logic [7:0] p2_reg_i = 8'hFF;
  logic [7:0] lo_in_i = '0;
  logic [7:0] lo_out_o, hi_out_o, rdata_o;
  logic       lo_oe_o, ale_o, rd_n_o, wr_n_o, done_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .wide_i(wide_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ws_i(ws_i),
    .ale_low_idle_i(ale_low_idle_i), .p0_reg_i(p0_reg_i),
    .p0_drive_idle_i(p0_drive_idle_i), .p2_reg_i(p2_reg_i), .lo_in_i(lo_in_i),
    .lo_out_o(lo_out_o), .lo_oe_o(lo_oe_o), .hi_out_o(hi_out_o), .ale_o(ale_o),
    .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .rdata_o(rdata_o), .done_o(done_o)
  );

  function automatic logic [7:0] exp_hi(input logic wide, input logic [15:0] a,
                                        input logic [7:0] p2);
    return wide ? a[15:8] : p2;
  endfunction

  function automatic int exp_len(input logic [1:0] ws);
    return 4 + int'(ws);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(ale_o == !ale_low_idle_i, {tag, " ale idle level"}, 32'(ale_o), 32'(!ale_low_idle_i));
    chk(rd_n_o && wr_n_o, {tag, " strobes high"}, {rd_n_o, wr_n_o}, 2'b11);
    chk(lo_out_o == p0_reg_i, {tag, " low port value"}, 32'(lo_out_o), 32'(p0_reg_i));
    chk(lo_oe_o == p0_drive_idle_i, {tag, " low port drive"}, 32'(lo_oe_o), 32'(p0_drive_idle_i));
    chk(hi_out_o == p2_reg_i, {tag, " high port value"}, 32'(hi_out_o), 32'(p2_reg_i));
    chk(!done_o, {tag, " no done"}, 32'(done_o), 0);
  endtask

  // One access; every cycle is checked at the negative edge.
  task automatic run_access(input logic wr, input logic wide, input logic [15:0] a,
                            input logic [7:0] d, input logic [1:0] ws);
    logic [7:0] exp_rd;
    logic [7:0] hi_e;
    int len;
    len = exp_len(ws);
    exp_rd = '0;
    req_i = 1'b1; wr_i = wr; wide_i = wide; addr_i = a; wdata_i = d; ws_i = ws;
    hi_e = exp_hi(wide, a, p2_reg_i);
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      // R8: busy-time request with scrambled fields, then garbage inputs
      req_i   = (c < 2);
      wr_i    = ~wr;
      ws_i    = ~ws;
      wide_i  = ~wide;
      addr_i  = ~a;
      wdata_i = ~d;
      chk(hi_out_o == hi_e, "R7 high port", 32'(hi_out_o), 32'(hi_e));
      chk(done_o == (c == len - 1), "R6 done timing", 32'(done_o), 32'(c == len - 1));
      if (c < 2) begin
        chk(ale_o == (c == 0), "R2 ale pulse", 32'(ale_o), 32'(c == 0));
        chk(lo_oe_o && lo_out_o == a[7:0], "R2 low address",
            {lo_oe_o, lo_out_o}, {1'b1, a[7:0]});
        chk(rd_n_o && wr_n_o, "R2 strobes high", {rd_n_o, wr_n_o}, 2'b11);
      end else if (c < len - 1) begin
        chk(!ale_o, "R5 ale low in strobe", 32'(ale_o), 0);
        if (wr) begin
          chk(!wr_n_o && rd_n_o, "R3 write strobe", {rd_n_o, wr_n_o}, 2'b10);
          chk(lo_oe_o && lo_out_o == d, "R3 write data", {lo_oe_o, lo_out_o}, {1'b1, d});
        end else begin
          chk(!rd_n_o && wr_n_o, "R4 read strobe", {rd_n_o, wr_n_o}, 2'b01);
          chk(!lo_oe_o, "R9 float on read", 32'(lo_oe_o), 0);
        end
        lo_in_i = 8'($urandom);
        exp_rd = lo_in_i;
      end else begin
        chk(!ale_o && rd_n_o && wr_n_o, "R6 tail pins", {ale_o, rd_n_o, wr_n_o}, 3'b011);
        chk(lo_oe_o == wr, "R6 tail drive", 32'(lo_oe_o), 32'(wr));
        if (!wr) chk(rdata_o == exp_rd, "R4 read data", 32'(rdata_o), 32'(exp_rd));
        if (wr) chk(lo_out_o == d, "R6 tail write data", 32'(lo_out_o), 32'(d));
      end
      if (c >= 2 && c < len - 1) lo_in_i = exp_rd;
    end
    @(negedge clk);
    chk_idle("R10 return to idle");
    @(negedge clk);
    chk_idle("R8 ignored request started nothing");
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk_idle("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 idle after reset");
    ale_low_idle_i = 1'b1;
    @(negedge clk);
    chk_idle("R1 idle polarity low");

    // directed corners
    p2_reg_i = 8'h3C; p0_reg_i = 8'hA5; p0_drive_idle_i = 1'b1;
    run_access(1'b1, 1'b1, 16'h1234, 8'h5A, 2'd0);
    run_access(1'b0, 1'b1, 16'hBEEF, 8'h00, 2'd3);
    ale_low_idle_i = 1'b0; p0_drive_idle_i = 1'b0;
    @(negedge clk);
    chk_idle("R1 idle float high ale");
    run_access(1'b0, 1'b0, 16'h0077, 8'h11, 2'd0);
    run_access(1'b1, 1'b0, 16'h00C3, 8'hE7, 2'd3);

    // constrained random
    for (int n = 0; n < 60; n++) begin
      ale_low_idle_i  = 1'($urandom);
      p0_drive_idle_i = 1'($urandom);
      p0_reg_i        = 8'($urandom);
      p2_reg_i        = 8'($urandom);
      @(negedge clk);
      chk_idle("R1 random idle");
      run_access(1'($urandom), 1'($urandom), 16'($urandom), 8'($urandom), 2'($urandom));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule